// File: doc/BRIEF.md
# Checksum-Augmented Matrix Multiply-Accumulate Array

This block multiplies a column-checksum-encoded left matrix (S+1 rows by S columns, with the last row carrying the column sums) by a row-checksum-encoded right matrix (S rows by S+1 columns, with the last column carrying the row sums). The result is the fully encoded product of S+1 by S+1 elements. The extra row and the extra column of that product are checksums. They come out of exactly the same multiply-accumulate datapath that produces the data, so a separate checker can later compare them against sums of the data rows and columns.

The array holds S+1 identical multiply-accumulate lanes, and lane j owns output column j. On every accepted step the producer presents one element of the current left-matrix row, which is broadcast to all lanes, together with the whole matching row of the right matrix, one operand per lane. After S accepted steps the lanes hold one complete output row. That row is presented for one cycle and written into a row store that holds S+1 rows. Operands from data positions are N-bit signed values. Operands from checksum positions are N + max(log2 S − R, 0) bits wide. All results wrap modulo 2^(2N).

A fault-forcing input can set one chosen accumulator bit in one chosen lane. It exists for fault-tolerance experiments on a bench.

Top module: `cs_mac_array`

## Requirements
- R1: Element j of an output row, held at bits [j*2N +: 2N] of `row_data`, equals the sum over k of a[i][k]·b[k][j], and lane j is the only lane that produces it.
- R2: Each element is the low 2N bits of the exact signed sum of products. Overflow wraps and is never saturated.
- R3: An output row takes exactly S accepted steps, where a step is a cycle with `in_valid` high. Cycles with `in_valid` low change nothing. `row_valid` pulses for one cycle, in the cycle after the S-th step, and `row_idx` counts 0 to S.
- R4: Each lane clears its accumulator on the first step of a row. A row's result does not depend on earlier rows or earlier matrices.
- R5: Each presented row is written to the store at its `row_idx`. `rd_data` returns store row `rd_addr` one cycle after the address is applied, and the store reads as zero after reset.
- R6: `mat_done` pulses together with the `row_valid` of row S. The next accepted step then begins row 0 of a new matrix.
- R7: When `flt_en` is high on an accepted step, bit `flt_bit` of lane `flt_lane`'s accumulator result for that step is forced to 1. No other lane and no other bit is affected.
- R8: With a=[[1,2],[3,4]] and b=[[5,6],[7,8]], encoded with S=2, the three rows are [19,22,41], [43,50,93] and [62,72,134].
- R9: With correctly encoded inputs, the last row equals the modulo-2^(2N) column sums of the data rows, and the last column equals the row sums of the data columns.
- R10: Operands in checksum positions (left row S, right lane S) use the full widened width, and values outside the N-bit range give exact results. Operands in data positions must be sign-extended N-bit values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Step accepted this cycle |
| in_a | input | CW | Left-matrix element, broadcast to all lanes |
| in_b | input | (S+1)*CW | Right-matrix row, lane j at [j*CW +: CW] |
| flt_en | input | 1 | Force a bit in the accumulator this step |
| flt_lane | input | LW | Lane to fault |
| flt_bit | input | BW | Bit to force high |
| row_valid | output | 1 | Completed output row present |
| row_idx | output | LW | Index of the presented row |
| row_data | output | (S+1)*2N | Presented row, lane j at [j*2N +: 2N] |
| mat_done | output | 1 | Last row of the matrix presented |
| rd_addr | input | LW | Store read row |
| rd_data | output | (S+1)*2N | Store read data, one-cycle latency |

## Verification
The embedded properties assume that data-position operands arrive sign-extended from N bits, both in every right-matrix lane below S and in left-matrix rows below S. Checksum positions may use the full widened range. The stimulus respects this by drawing data from the signed N-bit range and computing every checksum as an exact sum, which S·2^(N−1) keeps inside the widened width. Random matrices are mixed with extreme constant matrices that force wrap-around, with randomly placed idle cycles between steps, and with one fault experiment on a matrix whose clean results leave the forced bit at zero.

// File: rtl/cmac_pkg.sv
package cmac_pkg;

  // width of an index able to address v items, never below one bit
  function automatic int unsigned idx_width(int unsigned v);
    return (v < 2) ? 1 : $clog2(v);
  endfunction

  // operand width of checksum positions: N plus the growth left after truncation
  function automatic int unsigned cs_width(int unsigned n, int unsigned s, int unsigned r);
    int grow;
    grow = $clog2(s) - int'(r);
    return n + ((grow > 0) ? grow : 0);
  endfunction

endpackage

// File: rtl/cmac_lane.sv
module cmac_lane #(
  parameter int unsigned CW      = 10,
  parameter int unsigned OW      = 16,
  parameter int unsigned LW      = 3,
  parameter int unsigned BW      = 4,
  parameter int unsigned LANE_ID = 0,
  parameter bit          FAULT_EN = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step_en,
  input  logic          step_first,
  input  logic [CW-1:0] a_op,
  input  logic [CW-1:0] b_op,
  input  logic          flt_en,
  input  logic [LW-1:0] flt_lane,
  input  logic [BW-1:0] flt_bit,
  output logic [OW-1:0] acc
);

  // signed product reduced to the output ring
  function automatic logic [OW-1:0] ring_mul(logic [CW-1:0] x, logic [CW-1:0] y);
    logic signed [2*CW-1:0] p;
    p = $signed(x) * $signed(y);
    return p[OW-1:0];
  endfunction

  logic [OW-1:0] term;
  logic [OW-1:0] base;
  logic [OW-1:0] sum;
  logic [OW-1:0] flt_mask;
  logic          flt_hit;

  assign term = ring_mul(a_op, b_op);
  assign base = step_first ? '0 : acc;
  assign sum  = base + term;

  generate
    if (FAULT_EN) begin : g_fault
      assign flt_hit  = flt_en && (flt_lane == LW'(LANE_ID));
      assign flt_mask = flt_hit ? (OW'(1) << flt_bit) : '0;
    end else begin : g_nofault
      logic unused_flt;
      assign unused_flt = flt_en ^ (^flt_lane) ^ (^flt_bit);
      assign flt_hit  = 1'b0;
      assign flt_mask = '0;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       acc <= '0;
    else if (step_en) acc <= sum | flt_mask;
  end

  // R4: a first step leaves only its own product in the accumulator
  a_r4_row_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && step_first && !flt_hit) |=> (acc == $past(term)));

  // R3: idle cycles leave the accumulator untouched
  a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en |=> $stable(acc));

  // R7: a forced bit reads as one right after the step
  a_r7_fault_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && flt_hit) |=> acc[$past(flt_bit)]);

endmodule

// File: rtl/cmac_seq.sv
module cmac_seq #(
  parameter int unsigned S  = 4,
  parameter int unsigned KW = 2,
  parameter int unsigned LW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          step_first,
  output logic [LW-1:0] cur_row,
  output logic          row_valid,
  output logic [LW-1:0] row_idx,
  output logic          mat_done
);

  logic [KW-1:0] step_cnt;
  logic          step_last;
  logic          row_last;

  assign step_first = (step_cnt == '0);
  assign step_last  = (step_cnt == KW'(S-1));
  assign row_last   = (cur_row == LW'(S));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_cnt  <= '0;
      cur_row   <= '0;
      row_valid <= 1'b0;
      row_idx   <= '0;
      mat_done  <= 1'b0;
    end else begin
      row_valid <= in_valid && step_last;
      mat_done  <= in_valid && step_last && row_last;
      if (in_valid) begin
        if (step_last) begin
          step_cnt <= '0;
          row_idx  <= cur_row;
          cur_row  <= row_last ? '0 : cur_row + LW'(1);
        end else begin
          step_cnt <= step_cnt + KW'(1);
        end
      end
    end
  end

  // R3: a completed row is announced exactly one cycle after its last step
  a_r3_valid_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && step_last) |=> row_valid);

  a_r3_valid_needs_step: assert property (@(posedge clk) disable iff (!rst_n)
    row_valid |-> $past(in_valid));

  a_r3_row_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    row_valid |-> (row_idx <= LW'(S)));

  // R6: matrix completion coincides with the last row
  a_r6_done_last_row: assert property (@(posedge clk) disable iff (!rst_n)
    mat_done |-> (row_valid && row_idx == LW'(S)));

  a_r6_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    mat_done |-> (cur_row == '0));

endmodule

// File: rtl/cmac_store.sv
module cmac_store #(
  parameter int unsigned ROWS = 5,
  parameter int unsigned RW   = 80,
  parameter int unsigned AW   = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_idx,
  input  logic [RW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [RW-1:0] rd_data
);

  logic [RW-1:0] mem [ROWS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ROWS; i++) mem[i] <= '0;
      rd_data <= '0;
    end else begin
      if (wr_en && (wr_idx < AW'(ROWS))) mem[wr_idx] <= wr_data;
      rd_data <= (rd_addr < AW'(ROWS)) ? mem[rd_addr] : '0;
    end
  end

  // R5: a written row lands at its index
  a_r5_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx < AW'(ROWS)) |=> (mem[$past(wr_idx)] == $past(wr_data)));

endmodule

// File: rtl/cs_mac_array.sv
module cs_mac_array #(
  parameter int unsigned N        = 8,
  parameter int unsigned S        = 4,
  parameter int unsigned R        = 0,
  parameter bit          FAULT_EN = 1'b1,
  localparam int unsigned CW = cmac_pkg::cs_width(N, S, R),
  localparam int unsigned OW = 2 * N,
  localparam int unsigned LW = cmac_pkg::idx_width(S + 1),
  localparam int unsigned BW = cmac_pkg::idx_width(OW)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic [CW-1:0]         in_a,
  input  logic [(S+1)*CW-1:0]   in_b,
  input  logic                  flt_en,
  input  logic [LW-1:0]         flt_lane,
  input  logic [BW-1:0]         flt_bit,
  output logic                  row_valid,
  output logic [LW-1:0]         row_idx,
  output logic [(S+1)*OW-1:0]   row_data,
  output logic                  mat_done,
  input  logic [LW-1:0]         rd_addr,
  output logic [(S+1)*OW-1:0]   rd_data
);

  localparam int unsigned KW = cmac_pkg::idx_width(S);

  logic          step_first;
  logic [LW-1:0] cur_row;

  cmac_seq #(.S(S), .KW(KW), .LW(LW)) u_seq (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .step_first(step_first), .cur_row(cur_row),
    .row_valid(row_valid), .row_idx(row_idx), .mat_done(mat_done)
  );

  generate
    for (genvar j = 0; j <= S; j++) begin : g_lane
      logic [OW-1:0] lane_acc;
      cmac_lane #(
        .CW(CW), .OW(OW), .LW(LW), .BW(BW), .LANE_ID(j), .FAULT_EN(FAULT_EN)
      ) u_lane (
        .clk(clk), .rst_n(rst_n), .step_en(in_valid), .step_first(step_first),
        .a_op(in_a), .b_op(in_b[j*CW +: CW]),
        .flt_en(flt_en), .flt_lane(flt_lane), .flt_bit(flt_bit),
        .acc(lane_acc)
      );
      assign row_data[j*OW +: OW] = lane_acc;
    end
  endgenerate

  cmac_store #(.ROWS(S + 1), .RW((S + 1) * OW), .AW(LW)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(row_valid), .wr_idx(row_idx),
    .wr_data(row_data), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  // R10: data rows of the left matrix carry sign-extended N-bit values
  a_r10_data_row_range: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cur_row < LW'(S)) |->
      ((in_a[CW-1:N-1] == '0) || (&in_a[CW-1:N-1])));

  generate
    for (genvar j = 0; j < S; j++) begin : g_bchk
      // R10: data lanes of the right matrix carry sign-extended N-bit values
      a_r10_data_lane_range: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ((in_b[j*CW+N-1 +: CW-N+1] == '0) || (&in_b[j*CW+N-1 +: CW-N+1])));
    end
  endgenerate

endmodule

// File: tb/test_cs_mac_array.sv
module test_cs_mac_array;

  localparam int N  = 8;
  localparam int S  = 4;
  localparam int CW = 10;
  localparam int OW = 16;
  localparam int LW = 3;
  localparam int BW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic                 in_valid = 1'b0;
  logic [CW-1:0]        in_a = '0;
  logic [(S+1)*CW-1:0]  in_b = '0;
  logic                 flt_en = 1'b0;
  logic [LW-1:0]        flt_lane = '0;
  logic [BW-1:0]        flt_bit = '0;
  logic                 row_valid;
  logic [LW-1:0]        row_idx;
  logic [(S+1)*OW-1:0]  row_data;
  logic                 mat_done;
  logic [LW-1:0]        rd_addr = '0;
  logic [(S+1)*OW-1:0]  rd_data;

  cs_mac_array #(.N(N), .S(S), .R(0)) i_cs_mac_array (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
    .flt_en(flt_en), .flt_lane(flt_lane), .flt_bit(flt_bit),
    .row_valid(row_valid), .row_idx(row_idx), .row_data(row_data),
    .mat_done(mat_done), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  // small instance for the 2x2 worked example
  logic          s_valid = 1'b0;
  logic [8:0]    s_a = '0;
  logic [26:0]   s_b = '0;
  logic          s_row_valid;
  logic [1:0]    s_row_idx;
  logic [47:0]   s_row_data;
  logic          s_done;
  logic [47:0]   s_rd_data;

  cs_mac_array #(.N(8), .S(2), .R(0)) i_cs_mac_array_small (
    .clk(clk), .rst_n(rst_n), .in_valid(s_valid), .in_a(s_a), .in_b(s_b),
    .flt_en(1'b0), .flt_lane(2'd0), .flt_bit(4'd0),
    .row_valid(s_row_valid), .row_idx(s_row_idx), .row_data(s_row_data),
    .mat_done(s_done), .rd_addr(2'd0), .rd_data(s_rd_data)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  int am [0:S][0:S-1];
  int bm [0:S-1][0:S];
  logic [OW-1:0] exp_r [0:S][0:S];
  logic [OW-1:0] got   [0:S][0:S];
  int f_row = -1, f_lane = 0, f_bit = 0;
  int exp_row = 0;
  bit mon_on = 1'b0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // checksums as exact sums of the data
  task automatic encode();
    for (int k = 0; k < S; k++) begin
      am[S][k] = 0;
      for (int i = 0; i < S; i++) am[S][k] += am[i][k];
    end
    for (int k = 0; k < S; k++) begin
      bm[k][S] = 0;
      for (int j = 0; j < S; j++) bm[k][S] += bm[k][j];
    end
  endtask

  task automatic fill_random();
    for (int i = 0; i < S; i++)
      for (int j = 0; j < S; j++) begin
        am[i][j] = int'($urandom_range(255)) - 128;
        bm[i][j] = int'($urandom_range(255)) - 128;
      end
    encode();
  endtask

  task automatic fill_const(input int va, input int vb);
    for (int i = 0; i < S; i++)
      for (int j = 0; j < S; j++) begin
        am[i][j] = va;
        bm[i][j] = vb;
      end
    encode();
  endtask

  task automatic compute_expected();
    for (int i = 0; i <= S; i++)
      for (int j = 0; j <= S; j++) begin
        longint acc = 0;
        for (int k = 0; k < S; k++) acc += longint'(am[i][k]) * longint'(bm[k][j]);
        exp_r[i][j] = acc[OW-1:0];
        if (i == f_row && j == f_lane) exp_r[i][j] = exp_r[i][j] | (OW'(1) << f_bit);
      end
  endtask

  task automatic run_matrix(input int stall_pct);
    compute_expected();
    exp_row = 0;
    mon_on = 1'b1;
    for (int i = 0; i <= S; i++)
      for (int k = 0; k < S; k++) begin
        while (int'($urandom_range(99)) < stall_pct) begin
          in_valid = 1'b0;
          in_a = CW'(12345);
          flt_en = 1'b0;
          @(negedge clk);
        end
        in_valid = 1'b1;
        in_a = CW'(am[i][k]);
        for (int j = 0; j <= S; j++) in_b[j*CW +: CW] = CW'(bm[k][j]);
        flt_en = (i == f_row) && (k == S - 1);
        flt_lane = LW'(f_lane);
        flt_bit = BW'(f_bit);
        @(negedge clk);
      end
    in_valid = 1'b0;
    flt_en = 1'b0;
    repeat (4) @(negedge clk);
    mon_on = 1'b0;
    check(exp_row == S + 1, "R3 rows per matrix", exp_row, S + 1);
  endtask

  task automatic check_sums();
    for (int j = 0; j <= S; j++) begin
      logic [OW-1:0] cs = '0;
      for (int i = 0; i < S; i++) cs = cs + got[i][j];
      check(cs == got[S][j], "R9 column checksum row", got[S][j], cs);
    end
    for (int i = 0; i <= S; i++) begin
      logic [OW-1:0] rs = '0;
      for (int j = 0; j < S; j++) rs = rs + got[i][j];
      check(rs == got[i][S], "R9 row checksum column", got[i][S], rs);
    end
  endtask

  task automatic read_back();
    for (int i = 0; i <= S; i++) begin
      rd_addr = LW'(i);
      @(negedge clk);
      for (int j = 0; j <= S; j++)
        check(rd_data[j*OW +: OW] == exp_r[i][j], "R5 store readback",
              rd_data[j*OW +: OW], exp_r[i][j]);
    end
  endtask

  // row monitor, sampled on the falling edge
  always @(negedge clk) begin
    if (mon_on && row_valid) begin
      check(row_idx == LW'(exp_row), "R3 row index order", row_idx, exp_row);
      check(mat_done == (exp_row == S), "R6 done with last row", mat_done, exp_row == S);
      for (int j = 0; j <= S; j++) begin
        got[exp_row][j] = row_data[j*OW +: OW];
        check(row_data[j*OW +: OW] == exp_r[exp_row][j], "R1 R2 R4 R7 R10 lane result",
              row_data[j*OW +: OW], exp_r[exp_row][j]);
      end
      exp_row++;
    end
  end

  // 2x2 example monitor
  int s_row = 0;
  bit s_on = 1'b0;
  always @(negedge clk) begin
    if (s_on && s_row_valid) begin
      int ex [0:2][0:2];
      ex = '{'{19, 22, 41}, '{43, 50, 93}, '{62, 72, 134}};
      for (int j = 0; j < 3; j++)
        check(s_row_data[j*16 +: 16] == 16'(ex[s_row][j]), "R8 worked example",
              s_row_data[j*16 +: 16], ex[s_row][j]);
      s_row++;
    end
  end

  task automatic run_small();
    int a2 [0:2][0:1];
    int b2 [0:1][0:2];
    a2 = '{'{1, 2}, '{3, 4}, '{4, 6}};
    b2 = '{'{5, 6, 11}, '{7, 8, 15}};
    s_on = 1'b1;
    for (int i = 0; i < 3; i++)
      for (int k = 0; k < 2; k++) begin
        s_valid = 1'b1;
        s_a = 9'(a2[i][k]);
        for (int j = 0; j < 3; j++) s_b[j*9 +: 9] = 9'(b2[k][j]);
        @(negedge clk);
      end
    s_valid = 1'b0;
    repeat (3) @(negedge clk);
    s_on = 1'b0;
    check(s_row == 3, "R8 example row count", s_row, 3);
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !finished) begin
      finished = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(row_valid == 1'b0, "R3 reset row_valid", row_valid, 0);
    check(mat_done == 1'b0, "R6 reset mat_done", mat_done, 0);
    check(rd_data == '0, "R5 reset store", rd_data == '0, 1);
    rst_n = 1'b1;
    @(negedge clk);

    // random matrices, back-to-back then with idle gaps
    fill_random(); run_matrix(0); check_sums(); read_back();
    fill_random(); run_matrix(40); check_sums(); read_back();
    for (int t = 0; t < 6; t++) begin
      fill_random(); run_matrix(t * 10); check_sums();
    end
    // extremes: wrap-around and widened checksum range
    fill_const(-128, -128); run_matrix(0); check_sums(); read_back();
    fill_const(127, -128);  run_matrix(20); check_sums();
    fill_const(127, 127);   run_matrix(0); check_sums();
    // zeros after large values: row clearing
    fill_const(0, 0); run_matrix(0); check_sums();

    // fault forcing on one lane, one row, last step
    fill_const(1, 1);
    f_row = 1; f_lane = 2; f_bit = 9;
    run_matrix(10); read_back();
    f_row = -1;
    fill_random(); run_matrix(0); check_sums();

    run_small();

    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule